// File: doc/BRIEF.md
# Wait-Mode Wake-Up Sequencer

This block brings a processor out of its clock-gated wait state when a peripheral raises an interrupt. While the processor runs, a wait request stops the CPU clock. At that moment the block also captures three settings. The first is whether the internal regulator may drop into its low-power mode. The second is whether the flash memory is switched off. The third is whether interrupts are globally enabled. The regulator and flash enables then follow those settings for as long as the wait lasts.

Each peripheral source has a request line and a 3-bit priority level. When at least one requesting source has a nonzero level and interrupts were enabled at entry, the block wakes. It selects the source with the highest level and loads the wake clock selection into the active clock select output. It then steps through four timed phases in a fixed order: regulator power-up, flash activation, CPU clock restart and interrupt entry. After the last phase it returns to the running state and emits a one-cycle interrupt-take pulse carrying the index of the chosen source. The microsecond-scale waits are counted in cycles of the block clock, and the cycle counts are set by parameters. CPU-clock phases are counted on the same clock.

The states are RUN, WAIT, PWR, FLASH, CLKR and ISEQ. The transitions are:
- RUN to WAIT on a wait request.
- WAIT to PWR on a qualified wake when low-power regulation was enabled.
- WAIT to FLASH on a qualified wake otherwise.
- PWR to FLASH, FLASH to CLKR and CLKR to ISEQ, each when the phase counter expires.
- ISEQ to RUN when the interrupt-entry count expires.

Top module: `wake_seq`

## Requirements
- R1: After synchronous reset the block is in RUN. In that state cpu_clk_en, reg_en and flash_en are 1, irq_take is 0 and clk_sel is 0.
- R2: A wait_req seen in RUN stops the CPU clock from the next cycle on. While waiting, reg_en equals the inverse of lpm_en and flash_en equals the inverse of fstop, both as sampled with the wait request.
- R3: A requesting source whose level is 000 never wakes the block. A wake happens only when some requesting source has a nonzero level.
- R4: If gie was 0 when the wait was entered, no request wakes the block.
- R5: The phases run in the order PWR, FLASH, CLKR, ISEQ, and PWR is skipped when lpm_en was 0. reg_en is 1 from the first wake cycle on. flash_en rises when FLASH begins. cpu_clk_en rises only when ISEQ begins, with both enables already high.
- R6: Let the request be seen at a clock edge. The counted lengths are T0 = T0_CYC if lpm_en was 1, else 0; T1 = 1 + T1X_CYC if fstop was 1, else 1; T2 = T2_CYC; T3 = T3_CYC. cpu_clk_en is first 1 in cycle T0+T1+T2+1 after that edge, and irq_take is 1 in cycle T0+T1+T2+T3+1.
- R7: irq_id carries the index of the requesting source with the highest nonzero level. Among equal levels the lowest index wins. Source i uses irq_lvl bits [3i+2:3i].
- R8: irq_take is high for exactly one cycle. cpu_clk_en then stays 1 in RUN.
- R9: During the phases, changes to irq_req or irq_lvl and any wait_req alter neither the chosen index nor the timing.
- R10: clk_sel takes the value of wclk_sel present at the wake edge and holds it at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wait_req | input | 1 | Request to enter the wait state |
| gie | input | 1 | Global interrupt enable |
| lpm_en | input | 1 | Allow the regulator to drop to low power while waiting |
| fstop | input | 1 | Switch the flash off while waiting |
| wclk_sel | input | 3 | Clock selection to apply on wake |
| irq_req | input | NSRC | Per-source interrupt request |
| irq_lvl | input | 3*NSRC | Per-source priority levels, packed |
| reg_en | output | 1 | Full-power regulator request |
| flash_en | output | 1 | Flash enable request |
| cpu_clk_en | output | 1 | CPU clock enable |
| clk_sel | output | 3 | Active clock selection |
| irq_take | output | 1 | One-cycle interrupt-entry pulse |
| irq_id | output | IDW | Index of the chosen source |

## Verification
The bench sweeps all four regulator/flash combinations over several computed level patterns. It counts the cycle in which each enable rises and in which the take pulse fires, and compares them with the phase-length sum. This catches a design that skips or miscounts a phase or opens the clock early. Priority patterns with ties and with disabled (zero) levels target a wrong tie-break, which would report a higher index. They also target a design that wakes on a level-0 source. Mid-sequence bursts of higher-priority requests, stray wait requests and clock-selection changes catch a design that re-arbitrates or restarts. Waits entered with the global enable off must stay asleep indefinitely.

// File: rtl/wake_pkg.sv
package wake_pkg;
    typedef enum logic [2:0] {
        ST_RUN   = 3'd0,
        ST_WAIT  = 3'd1,
        ST_PWR   = 3'd2,
        ST_FLASH = 3'd3,
        ST_CLKR  = 3'd4,
        ST_ISEQ  = 3'd5
    } wake_state_e;
endpackage

// File: rtl/wake_arb.sv
// Picks the requesting source with the highest nonzero level; ties go to the lowest index.
module wake_arb #(
    parameter int NSRC = 4,
    parameter int LVLW = 3,
    parameter int IDW  = 2
) (
    input  logic [NSRC-1:0]      req,
    input  logic [NSRC*LVLW-1:0] lvl,
    output logic                 valid,
    output logic [IDW-1:0]       id
);
    logic [LVLW-1:0] best;
    logic [LVLW-1:0] lv;

    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '0;
        lv    = '0;
        for (int i = 0; i < NSRC; i++) begin
            lv = lvl[i*LVLW +: LVLW];
            // strict compare keeps the earlier index on a tie and rejects level 0
            if (req[i] && (lv > best)) begin
                best  = lv;
                id    = IDW'(i);
                valid = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wake_timer.sv
// Shared down-counter: a phase lasts load_val+1 cycles after the load.
module wake_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
    import wake_pkg::*;
#(
    parameter int NSRC    = 4,
    parameter int T0_CYC  = 1600,
    parameter int T1X_CYC = 960,
    parameter int T2_CYC  = 2,
    parameter int T3_CYC  = 20,
    parameter int LVLW    = 3,
    parameter int SELW    = 3,
    parameter int IDW     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wait_req,
    input  logic                 gie,
    input  logic                 lpm_en,
    input  logic                 fstop,
    input  logic [SELW-1:0]      wclk_sel,
    input  logic [NSRC-1:0]      irq_req,
    input  logic [NSRC*LVLW-1:0] irq_lvl,
    output logic                 reg_en,
    output logic                 flash_en,
    output logic                 cpu_clk_en,
    output logic [SELW-1:0]      clk_sel,
    output logic                 irq_take,
    output logic [IDW-1:0]       irq_id
);
    localparam int T1_LONG = 1 + T1X_CYC;
    localparam int MAX_A   = (T0_CYC > T1_LONG) ? T0_CYC : T1_LONG;
    localparam int MAX_B   = (T2_CYC > T3_CYC) ? T2_CYC : T3_CYC;
    localparam int MAXD    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAXD + 1);

    wake_state_e     state_q, state_nxt;
    logic            lpm_q, fstop_q, gie_q;
    logic [IDW-1:0]  win_q;
    logic [SELW-1:0] sel_q;
    logic            take_q;
    logic            arb_valid;
    logic [IDW-1:0]  arb_id;
    logic            tmr_load, tmr_zero;
    logic [CW-1:0]   tmr_val;
    logic            wake_go;

    wake_arb #(.NSRC(NSRC), .LVLW(LVLW), .IDW(IDW)) u_arb (
        .req   (irq_req),
        .lvl   (irq_lvl),
        .valid (arb_valid),
        .id    (arb_id)
    );

    wake_timer #(.CW(CW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign wake_go = gie_q && arb_valid;

    // next state and phase-length loads
    always_comb begin
        state_nxt = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_RUN: begin
                if (wait_req) state_nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (wake_go) begin
                    tmr_load = 1'b1;
                    if (lpm_q) begin
                        state_nxt = ST_PWR;
                        tmr_val   = CW'(T0_CYC - 1);
                    end else begin
                        state_nxt = ST_FLASH;
                        tmr_val   = fstop_q ? CW'(T1_LONG - 1) : CW'(0);
                    end
                end
            end
            ST_PWR: begin
                if (tmr_zero) begin
                    state_nxt = ST_FLASH;
                    tmr_load  = 1'b1;
                    tmr_val   = fstop_q ? CW'(T1_LONG - 1) : CW'(0);
                end
            end
            ST_FLASH: begin
                if (tmr_zero) begin
                    state_nxt = ST_CLKR;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(T2_CYC - 1);
                end
            end
            ST_CLKR: begin
                if (tmr_zero) begin
                    state_nxt = ST_ISEQ;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(T3_CYC - 1);
                end
            end
            ST_ISEQ: begin
                if (tmr_zero) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
    end

    // state register and captured context
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            lpm_q   <= 1'b0;
            fstop_q <= 1'b0;
            gie_q   <= 1'b0;
            win_q   <= '0;
            sel_q   <= '0;
            take_q  <= 1'b0;
        end else begin
            state_q <= state_nxt;
            take_q  <= (state_q == ST_ISEQ) && (state_nxt == ST_RUN);
            if (state_q == ST_RUN && wait_req) begin
                lpm_q   <= lpm_en;
                fstop_q <= fstop;
                gie_q   <= gie;
            end
            if (state_q == ST_WAIT && wake_go) begin
                win_q <= arb_id;
                sel_q <= wclk_sel;
            end
        end
    end

    // outputs
    always_comb begin
        reg_en     = 1'b1;
        flash_en   = 1'b1;
        cpu_clk_en = 1'b0;
        unique case (state_q)
            ST_RUN:   cpu_clk_en = 1'b1;
            ST_WAIT: begin
                reg_en   = !lpm_q;
                flash_en = !fstop_q;
            end
            ST_PWR:   flash_en = !fstop_q;
            ST_FLASH: flash_en = 1'b1;
            ST_CLKR:  flash_en = 1'b1;
            ST_ISEQ:  cpu_clk_en = 1'b1;
            default:  cpu_clk_en = 1'b1;
        endcase
    end

    assign clk_sel  = sel_q;
    assign irq_take = take_q;
    assign irq_id   = win_q;

    AST_WAKE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && state_nxt != ST_WAIT) |-> arb_valid); // R3
    AST_NO_WAKE_GIE_OFF: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !gie_q) |=> (state_q == ST_WAIT)); // R4
    AST_CLK_AFTER_POWER: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> (flash_en && reg_en && !irq_take)); // R5
    AST_CLKR_TO_ISEQ: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CLKR) |=> (state_q == ST_CLKR || state_q == ST_ISEQ)); // R5
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_take); // R8
    AST_ID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN && state_q != ST_WAIT) |=> $stable(irq_id)); // R9
    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_WAIT) |=> $stable(clk_sel)); // R10
endmodule

// File: tb/wake_seq_tb.sv
module wake_seq_tb;
    localparam int NSRC = 4;
    localparam int T0   = 5;
    localparam int T1X  = 3;
    localparam int T2   = 2;
    localparam int T3   = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wait_req = 1'b0;
    logic            gie = 1'b0;
    logic            lpm_en = 1'b0;
    logic            fstop = 1'b0;
    logic [2:0]      wclk_sel = 3'd0;
    logic [NSRC-1:0] irq_req = '0;
    logic [NSRC*3-1:0] irq_lvl = '0;
    logic            reg_en, flash_en, cpu_clk_en, irq_take;
    logic [2:0]      clk_sel;
    logic [1:0]      irq_id;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    wake_seq #(.NSRC(NSRC), .T0_CYC(T0), .T1X_CYC(T1X), .T2_CYC(T2), .T3_CYC(T3)) u_dut (
        .clk(clk), .rst(rst), .wait_req(wait_req), .gie(gie), .lpm_en(lpm_en),
        .fstop(fstop), .wclk_sel(wclk_sel), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .reg_en(reg_en), .flash_en(flash_en), .cpu_clk_en(cpu_clk_en),
        .clk_sel(clk_sel), .irq_take(irq_take), .irq_id(irq_id)
    );

    task automatic check_eq(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; irq_req = '0; irq_lvl = '0; wait_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 clk_en", int'(cpu_clk_en), 1);
        check_eq("R1 reg_en", int'(reg_en), 1);
        check_eq("R1 flash_en", int'(flash_en), 1);
        check_eq("R1 take", int'(irq_take), 0);
        check_eq("R1 clk_sel", int'(clk_sel), 0);
    endtask

    task automatic enter_wait(bit l, bit f, bit g);
        @(negedge clk);
        lpm_en = l; fstop = f; gie = g; wait_req = 1'b1;
        @(negedge clk);
        wait_req = 1'b0;
        lpm_en = ~l; fstop = ~f; gie = ~g;  // later changes must not matter
        check_eq("R2 clk stopped", int'(cpu_clk_en), 0);
        check_eq("R2 reg_en", int'(reg_en), int'(!l));
        check_eq("R2 flash_en", int'(flash_en), int'(!f));
    endtask

    function automatic int exp_winner(logic [NSRC-1:0] rq, logic [NSRC*3-1:0] lv);
        int best = 0;
        int id = -1;
        for (int i = 0; i < NSRC; i++) begin
            if (rq[i] && int'(lv[i*3 +: 3]) > best) begin
                best = int'(lv[i*3 +: 3]);
                id = i;
            end
        end
        return id;
    endfunction

    task automatic run_wake(bit l, bit f, logic [NSRC-1:0] rq, logic [NSRC*3-1:0] lv,
                            logic [2:0] sel, bit disturb);
        int t0e = l ? T0 : 0;
        int t1e = f ? (1 + T1X) : 1;
        int win = exp_winner(rq, lv);
        int k_reg = -1, k_fl = -1, k_clk = -1, k_take = -1;
        enter_wait(l, f, 1'b1);
        repeat (2) @(negedge clk);
        irq_req = rq; irq_lvl = lv; wclk_sel = sel;
        for (int k = 1; k < 300; k++) begin
            @(negedge clk);
            if (reg_en && k_reg < 0) k_reg = k;
            if (flash_en && k_fl < 0) k_fl = k;
            if (cpu_clk_en && k_clk < 0) k_clk = k;
            if (disturb && k == 2) begin
                irq_req = '1; irq_lvl = '1; wait_req = 1'b1; wclk_sel = ~sel;
            end
            if (disturb && k == 3) wait_req = 1'b0;
            if (irq_take) begin
                k_take = k;
                break;
            end
        end
        if (l) check_eq("R5 reg_en rise", k_reg, 1);
        if (f) check_eq("R5 flash_en rise", k_fl, t0e + 1);
        check_eq("R6 clock restart cycle", k_clk, t0e + t1e + T2 + 1);
        check_eq(disturb ? "R9 take cycle" : "R6 take cycle", k_take, t0e + t1e + T2 + T3 + 1);
        check_eq(disturb ? "R9 irq_id" : "R7 irq_id", int'(irq_id), win);
        check_eq("R10 clk_sel", int'(clk_sel), int'(sel));
        irq_req = '0; irq_lvl = '0; wclk_sel = ~sel;
        @(negedge clk);
        check_eq("R8 take low", int'(irq_take), 0);
        check_eq("R8 clk on", int'(cpu_clk_en), 1);
        check_eq("R10 clk_sel held", int'(clk_sel), int'(sel));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R6 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [NSRC*3-1:0] lv;
        logic [NSRC-1:0] rq;
        do_reset();
        // sweep regulator/flash settings over computed level patterns
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 8; p++) begin
                for (int i = 0; i < NSRC; i++) lv[i*3 +: 3] = 3'((p * 5 + i * 3 + c) % 8);
                rq = (p % 3 == 0) ? 4'b1101 : 4'b1111;
                if (exp_winner(rq, lv) >= 0)
                    run_wake(c[0], c[1], rq, lv, 3'((p + c) % 8), 1'b0);
            end
        end
        // R7 ties: levels {1,5,5,3} -> index 1; all equal -> index 0
        run_wake(1'b0, 1'b1, 4'b1111, {3'd3, 3'd5, 3'd5, 3'd1}, 3'd6, 1'b0);
        run_wake(1'b1, 1'b0, 4'b1111, {3'd4, 3'd4, 3'd4, 3'd4}, 3'd2, 1'b0);
        // R7 zero level on highest-index source, non-requesting high level ignored
        run_wake(1'b0, 1'b0, 4'b1011, {3'd0, 3'd7, 3'd2, 3'd2}, 3'd1, 1'b0);
        // R9 disturbances during the sequence
        run_wake(1'b1, 1'b1, 4'b1111, {3'd3, 3'd6, 3'd2, 3'd1}, 3'd5, 1'b1);
        run_wake(1'b0, 1'b0, 4'b0110, {3'd0, 3'd4, 3'd1, 3'd0}, 3'd3, 1'b1);
        // R3: all levels zero never wake
        enter_wait(1'b0, 1'b0, 1'b1);
        irq_req = '1; irq_lvl = '0;
        repeat (60) @(negedge clk);
        check_eq("R3 asleep clk", int'(cpu_clk_en), 0);
        check_eq("R3 asleep take", int'(irq_take), 0);
        do_reset();
        // R4: interrupts disabled at entry never wake
        enter_wait(1'b1, 1'b1, 1'b0);
        irq_req = '1; irq_lvl = '1;
        repeat (60) @(negedge clk);
        check_eq("R4 asleep clk", int'(cpu_clk_en), 0);
        check_eq("R4 asleep reg", int'(reg_en), 0);
        check_eq("R4 asleep take", int'(irq_take), 0);
        do_reset();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule